// File: doc/BRIEF.md
# PCI Host Bridge Register Block

This block is the processor-facing register file of a PCI host bridge. A 32-bit register bus with a valid/ready handshake reaches four things:
- a local 256-byte configuration header,
- a configuration address register,
- a memory base register,
- an I/O base register.

One further offset acts as a data port. Each access to the data port becomes a single indirect configuration cycle on a downstream request/response stream. The target of that cycle is whatever the configuration address register holds. The block also drives the offset of the I/O window from the I/O base register, and it routes interrupt sources onto four interrupt lines by the slot number of each source.

Accesses to the local registers complete in the cycle in which the request is presented: `bus_ready` is combinational on `bus_valid`. A data-port access stalls the bus instead. `bus_ready` stays low until the downstream stream has taken the request and returned a response, or until a timeout expires.

Back-pressure rules:
- The register-bus master must hold all of its request fields stable while `bus_valid` is high and `bus_ready` is low.
- On the downstream side, a request stays on `cfg_req_*` until `cfg_req_ready` is seen. The only exception is the timeout, which withdraws the request.
- A response is accepted only while `cfg_rsp_ready` is high.
- Only one indirect cycle is ever outstanding.

Top module: `pcih_host_regs`

## Requirements
- R1: A register-bus access is acted on only when `bus_be` is 4'hF and `bus_addr[1:0]` is 2'b00. Any other access completes in the same cycle. As a write it changes nothing, as a read it returns zero, and it starts no downstream cycle.
- R2: Byte offsets 0x000 to 0x0FC read and write the 64 words of the local configuration header, each as a full 32-bit little-endian word (byte 0 of the header is bits 7:0 of word 0).
- R3: After reset, header word 1 (offset 0x004) reads 32'h0290_0080. That value is made of:
  - command word bit 7;
  - status word bit 4, status word bit 7, and status bits 10:9 = 01 (in the upper half of the word).

  Every other header word, the address register, the memory base register, the I/O base register and `io_win_off` read zero.
- R4: Offset 0x1C0 is the configuration address register; it stores and returns all 32 written bits.
- R5: Offset 0x1C4 is the memory base register; it stores the written value AND 32'hFF00_0001.
- R6: Offset 0x1C8 is the I/O base register; it stores the written value AND 32'hFFFC_0001, and `io_win_off` carries the written value AND 32'hFFFC_0000 from the cycle after the write.
- R7: A full-word write to offset 0x220 issues one downstream request with `cfg_req_write`=1, `cfg_req_addr` equal to the address register and `cfg_req_wdata` equal to the written data. A full-word read of 0x220 issues one request with `cfg_req_write`=0 and returns `cfg_rsp_rdata`.
- R8: While a data-port access is in flight, `bus_ready` stays low. An unaccepted request holds its address and data. With a request accepted after d stall cycles and a response presented r cycles later, the access completes 3+d+r cycles after it was first presented.
- R9: If an indirect cycle has not completed within TIMEOUT_CYC cycles of being issued, it ends anyway. A read then returns 32'hFFFF_FFFF, and the block accepts the next access normally.
- R10: Every other offset below 0x400 ignores writes and reads zero. This covers 0x100 to 0x1BC, 0x1CC to 0x21C, and 0x224 and above.
- R11: `irq_out[i]` is high exactly when at least one source j has `irq_src[j]` high and slot number `irq_slot[j*SLOT_W +: SLOT_W]` equal to i. A source with a slot number of 4 or more drives no line.
- R12: Accesses other than to the data port complete with `bus_ready` high in the same cycle `bus_valid` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Register-bus request valid |
| bus_ready | output | 1 | Register-bus request done (read data valid) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset |
| bus_be | input | 4 | Byte enables; only 4'hF acts |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| cfg_req_valid | output | 1 | Downstream configuration request valid |
| cfg_req_ready | input | 1 | Downstream takes the request |
| cfg_req_write | output | 1 | 1 = configuration write |
| cfg_req_addr | output | 32 | Configuration address (from address register) |
| cfg_req_wdata | output | 32 | Configuration write data |
| cfg_rsp_valid | input | 1 | Downstream response valid (also acks writes) |
| cfg_rsp_ready | output | 1 | Block waits for a response |
| cfg_rsp_rdata | input | 32 | Configuration read data |
| io_win_off | output | 32 | I/O window offset |
| irq_src | input | NUM_SRC | Interrupt request per source |
| irq_slot | input | NUM_SRC*SLOT_W | Slot number per source, packed |
| irq_out | output | 4 | Routed interrupt lines |

## Verification
A local access is due in the same cycle it is presented, so the bench samples `bus_ready` and `bus_rdata` one time step after driving a request on a falling edge. A data-port access is due exactly 3+d+r cycles later. The bench's responder sets d and r, and the bench compares the counted wait against that figure. `io_win_off` is due one cycle after the I/O base write and `irq_out` is combinational. Both are compared with the bench's reference model on every falling edge.

// File: rtl/pcih_pkg.sv
package pcih_pkg;
  localparam int BUS_AW   = 10;
  localparam int DW       = 32;
  localparam int HDR_WORDS = 64;
  localparam int IRQ_LINES = 4;

  localparam logic [7:0] W_ADDR = 8'h70;
  localparam logic [7:0] W_MBAS = 8'h71;
  localparam logic [7:0] W_IOBS = 8'h72;
  localparam logic [7:0] W_PORT = 8'h88;

  localparam logic [DW-1:0] MBAS_KEEP = 32'hFF00_0001;
  localparam logic [DW-1:0] IOBS_KEEP = 32'hFFFC_0001;
  localparam logic [DW-1:0] IOWIN_KEEP = 32'hFFFC_0000;
  localparam logic [DW-1:0] HDR1_RESET = 32'h0290_0080;

  typedef enum logic [2:0] {
    SEL_HDR, SEL_ADDR, SEL_MBAS, SEL_IOBS, SEL_PORT, SEL_NONE
  } sel_e;

  typedef enum logic [1:0] {
    ENG_IDLE, ENG_ISSUE, ENG_WAIT, ENG_DONE
  } eng_e;

  function automatic sel_e decode_word(input logic [7:0] w);
    if (w < 8'(HDR_WORDS)) return SEL_HDR;
    case (w)
      W_ADDR:  return SEL_ADDR;
      W_MBAS:  return SEL_MBAS;
      W_IOBS:  return SEL_IOBS;
      W_PORT:  return SEL_PORT;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic logic [DW-1:0] hdr_reset(input int idx);
    return (idx == 1) ? HDR1_RESET : '0;
  endfunction
endpackage

// File: rtl/pcih_cfg_space.sv
module pcih_cfg_space #(
  parameter int WORDS = 64,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data
);
  logic [DW-1:0] hdr [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) hdr[i] <= pcih_pkg::hdr_reset(i);
    end else if (wr_en) begin
      hdr[wr_idx] <= wr_data;
    end
  end

  assign rd_data = hdr[rd_idx];
endmodule

// File: rtl/pcih_indirect_eng.sv
module pcih_indirect_eng #(
  parameter int DW          = 32,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_write,
  input  logic [DW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  output logic          idle,
  output logic          done,
  output logic [DW-1:0] done_rdata,
  output logic          cfg_req_valid,
  input  logic          cfg_req_ready,
  output logic          cfg_req_write,
  output logic [DW-1:0] cfg_req_addr,
  output logic [DW-1:0] cfg_req_wdata,
  input  logic          cfg_rsp_valid,
  output logic          cfg_rsp_ready,
  input  logic [DW-1:0] cfg_rsp_rdata
);
  import pcih_pkg::*;
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYC - 1);

  eng_e          st;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic [DW-1:0] addr_q, wdata_q, rdata_q;
  logic          rsp_hit, tmo_hit;

  assign rsp_hit = (st == ENG_WAIT) && cfg_rsp_valid;
  assign tmo_hit = ((st == ENG_ISSUE) || (st == ENG_WAIT)) && !rsp_hit && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ENG_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        ENG_IDLE: if (start) begin
          st      <= ENG_ISSUE;
          cnt     <= '0;
          wr_q    <= start_write;
          addr_q  <= start_addr;
          wdata_q <= start_wdata;
        end
        ENG_ISSUE: begin
          cnt <= cnt + 1'b1;
          if (tmo_hit) begin
            st      <= ENG_DONE;
            rdata_q <= '1;
          end else if (cfg_req_ready) begin
            st <= ENG_WAIT;
          end
        end
        ENG_WAIT: begin
          cnt <= cnt + 1'b1;
          if (rsp_hit) begin
            st      <= ENG_DONE;
            rdata_q <= wr_q ? '0 : cfg_rsp_rdata;
          end else if (tmo_hit) begin
            st      <= ENG_DONE;
            rdata_q <= '1;
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  assign idle          = (st == ENG_IDLE);
  assign done          = (st == ENG_DONE);
  assign done_rdata    = rdata_q;
  assign cfg_req_valid = (st == ENG_ISSUE);
  assign cfg_req_write = wr_q;
  assign cfg_req_addr  = addr_q;
  assign cfg_req_wdata = wdata_q;
  assign cfg_rsp_ready = (st == ENG_WAIT);

  // R8: a request not yet taken keeps its contents
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && !cfg_req_ready && !tmo_hit) |=>
      (cfg_req_valid && $stable(cfg_req_addr) && $stable(cfg_req_wdata) && $stable(cfg_req_write)));

  // R9: a read that timed out returns all ones
  a_r9_timeout_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && !wr_q) |=> (done && done_rdata == '1));

  // R8: request and response phases never overlap
  a_r8_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req_valid && cfg_rsp_ready));
endmodule

// File: rtl/pcih_irq_route.sv
module pcih_irq_route #(
  parameter int NUM_SRC = 8,
  parameter int SLOT_W  = 5,
  parameter int LINES   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        irq_src,
  input  logic [NUM_SRC*SLOT_W-1:0] irq_slot,
  output logic [LINES-1:0]          irq_out
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_comb begin
      irq_out[i] = 1'b0;
      for (int j = 0; j < NUM_SRC; j++) begin
        if (irq_src[j] && (irq_slot[j*SLOT_W +: SLOT_W] == SLOT_W'(i))) irq_out[i] = 1'b1;
      end
    end
  end

  // R11: no line is raised without a source behind it
  a_r11_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= $countones(irq_src));
endmodule

// File: rtl/pcih_host_regs.sv
module pcih_host_regs #(
  parameter int NUM_SRC     = 8,
  parameter int SLOT_W      = 5,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_valid,
  output logic                      bus_ready,
  input  logic                      bus_write,
  input  logic [9:0]                bus_addr,
  input  logic [3:0]                bus_be,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      cfg_req_valid,
  input  logic                      cfg_req_ready,
  output logic                      cfg_req_write,
  output logic [31:0]               cfg_req_addr,
  output logic [31:0]               cfg_req_wdata,
  input  logic                      cfg_rsp_valid,
  output logic                      cfg_rsp_ready,
  input  logic [31:0]               cfg_rsp_rdata,
  output logic [31:0]               io_win_off,
  input  logic [NUM_SRC-1:0]        irq_src,
  input  logic [NUM_SRC*SLOT_W-1:0] irq_slot,
  output logic [3:0]                irq_out
);
  import pcih_pkg::*;
  localparam int IW = $clog2(HDR_WORDS);

  logic [7:0]  widx;
  logic        whole;
  sel_e        sel;
  logic        port_acc, local_acc, local_wr;
  logic [31:0] addr_reg, mbas_reg, iobs_reg, hdr_rd;
  logic        eng_idle, eng_done;
  logic [31:0] eng_rdata;

  assign widx      = bus_addr[9:2];
  assign whole     = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  assign sel       = decode_word(widx);
  assign port_acc  = bus_valid && whole && (sel == SEL_PORT);
  assign local_acc = bus_valid && !port_acc;
  assign local_wr  = local_acc && bus_write && whole;

  pcih_cfg_space #(.WORDS(HDR_WORDS), .DW(DW)) u_hdr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (local_wr && (sel == SEL_HDR)),
    .wr_idx  (widx[IW-1:0]),
    .wr_data (bus_wdata),
    .rd_idx  (widx[IW-1:0]),
    .rd_data (hdr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_reg <= '0;
      mbas_reg <= '0;
      iobs_reg <= '0;
    end else if (local_wr) begin
      case (sel)
        SEL_ADDR: addr_reg <= bus_wdata;
        SEL_MBAS: mbas_reg <= bus_wdata & MBAS_KEEP;
        SEL_IOBS: iobs_reg <= bus_wdata & IOBS_KEEP;
        default: ;
      endcase
    end
  end

  assign io_win_off = iobs_reg & IOWIN_KEEP;

  pcih_indirect_eng #(.DW(DW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (port_acc && eng_idle),
    .start_write   (bus_write),
    .start_addr    (addr_reg),
    .start_wdata   (bus_wdata),
    .idle          (eng_idle),
    .done          (eng_done),
    .done_rdata    (eng_rdata),
    .cfg_req_valid (cfg_req_valid),
    .cfg_req_ready (cfg_req_ready),
    .cfg_req_write (cfg_req_write),
    .cfg_req_addr  (cfg_req_addr),
    .cfg_req_wdata (cfg_req_wdata),
    .cfg_rsp_valid (cfg_rsp_valid),
    .cfg_rsp_ready (cfg_rsp_ready),
    .cfg_rsp_rdata (cfg_rsp_rdata)
  );

  assign bus_ready = local_acc || (port_acc && eng_done);

  always_comb begin
    bus_rdata = '0;
    if (port_acc) begin
      bus_rdata = eng_rdata;
    end else if (whole) begin
      case (sel)
        SEL_HDR:  bus_rdata = hdr_rd;
        SEL_ADDR: bus_rdata = addr_reg;
        SEL_MBAS: bus_rdata = mbas_reg;
        SEL_IOBS: bus_rdata = iobs_reg;
        default:  bus_rdata = '0;
      endcase
    end
  end

  pcih_irq_route #(.NUM_SRC(NUM_SRC), .SLOT_W(SLOT_W), .LINES(IRQ_LINES)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_src  (irq_src),
    .irq_slot (irq_slot),
    .irq_out  (irq_out)
  );

  // R1: an access that is not a whole aligned word reads zero
  a_r1_partial_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !whole) |-> (bus_rdata == '0));

  // R5: memory base never shows bits outside its kept field
  a_r5_mbas_field: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && whole && !bus_write && sel == SEL_MBAS) |-> ((bus_rdata & ~MBAS_KEEP) == '0));

  // R8: the bus is stalled while the downstream request is pending
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (port_acc && (cfg_req_valid || cfg_rsp_ready)) |-> !bus_ready);

  // R12: a non-port access is answered in the cycle it is presented
  a_r12_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !port_acc) |-> bus_ready);
endmodule

// File: tb/pcih_host_regs_bench.sv
module pcih_host_regs_bench;
  localparam int NS = 8;
  localparam int SW = 5;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready;
  logic [31:0] bus_rdata;
  logic cfg_req_valid, cfg_req_write, cfg_rsp_ready;
  logic cfg_req_ready = 1'b0, cfg_rsp_valid = 1'b0;
  logic [31:0] cfg_req_addr, cfg_req_wdata;
  logic [31:0] cfg_rsp_rdata = '0;
  logic [31:0] io_win_off;
  logic [NS-1:0] irq_src = '0;
  logic [NS*SW-1:0] irq_slot = '0;
  logic [3:0] irq_out;

  always #5 clk = ~clk;

  pcih_host_regs #(.NUM_SRC(NS), .SLOT_W(SW), .TIMEOUT_CYC(TMO)) u_pcih_host_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
    .cfg_req_write(cfg_req_write), .cfg_req_addr(cfg_req_addr), .cfg_req_wdata(cfg_req_wdata),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_ready(cfg_rsp_ready), .cfg_rsp_rdata(cfg_rsp_rdata),
    .io_win_off(io_win_off), .irq_src(irq_src), .irq_slot(irq_slot), .irq_out(irq_out)
  );

  int tests = 0, fails = 0;
  logic [31:0] m_iobs = '0;
  logic [31:0] dmem [int];
  int req_dly = 0, rsp_dly = 0;
  bit mute = 0;
  int n_req = 0;
  logic lat_wr;
  logic [31:0] lat_addr, lat_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dflt(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [3:0] irq_model(input logic [NS-1:0] s, input logic [NS*SW-1:0] sl);
    logic [3:0] r = '0;
    for (int j = 0; j < NS; j++) begin
      int k = int'(sl[j*SW +: SW]);
      if (s[j] && k < 4) r[k] = 1'b1;
    end
    return r;
  endfunction

  // downstream responder
  initial begin
    forever begin
      @(negedge clk);
      if (cfg_req_valid) begin
        repeat (req_dly) @(negedge clk);
        cfg_req_ready = 1'b1;
        lat_wr = cfg_req_write; lat_addr = cfg_req_addr; lat_wdata = cfg_req_wdata;
        @(negedge clk);
        cfg_req_ready = 1'b0;
        n_req++;
        if (lat_wr) dmem[int'(lat_addr)] = lat_wdata;
        if (!mute) begin
          repeat (rsp_dly) @(negedge clk);
          cfg_rsp_valid = 1'b1;
          cfg_rsp_rdata = lat_wr ? 32'h0 : (dmem.exists(int'(lat_addr)) ? dmem[int'(lat_addr)] : dflt(lat_addr));
          @(negedge clk);
          cfg_rsp_valid = 1'b0;
        end
      end
    end
  end

  // per-cycle reference comparison of io_win_off (R6) and irq_out (R11)
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        check("R6 io_win_off", io_win_off, m_iobs & 32'hFFFC_0000);
        check("R11 irq_out", {28'h0, irq_out}, {28'h0, irq_model(irq_src, irq_slot)});
      end
    end
  end

  task automatic xfer(input logic wr, input logic [9:0] a, input logic [3:0] be,
                      input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
    cyc = 0;
    #1;
    while (!bus_ready && cyc < 200) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    rd = bus_rdata;
    @(posedge clk);
    if (wr && be == 4'hF && a == 10'h1C8) m_iobs = wd & 32'hFFFC_0001;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wr32(input logic [9:0] a, input logic [31:0] d);
    logic [31:0] rd; int c;
    xfer(1'b1, a, 4'hF, d, rd, c);
  endtask

  task automatic rd32(input logic [9:0] a, output logic [31:0] d, output int c);
    xfer(1'b0, a, 4'hF, 32'h0, d, c);
  endtask

  initial begin
    logic [31:0] v; int c, nb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R3 reset bus_ready idle", {31'h0, bus_ready}, 32'h0);
    check("R3 reset io_win_off", io_win_off, 32'h0);

    rd32(10'h004, v, c); check("R3 header word1 reset", v, 32'h0290_0080);
    check("R12 same-cycle read", c, 0);
    rd32(10'h000, v, c); check("R3 header word0 reset", v, 32'h0);
    rd32(10'h0FC, v, c); check("R3 header word63 reset", v, 32'h0);
    rd32(10'h1C0, v, c); check("R3 addr reg reset", v, 32'h0);
    rd32(10'h1C4, v, c); check("R3 mem base reset", v, 32'h0);
    rd32(10'h1C8, v, c); check("R3 io base reset", v, 32'h0);

    wr32(10'h008, 32'hDEAD_BEEF); rd32(10'h008, v, c); check("R2 header word2", v, 32'hDEAD_BEEF);
    wr32(10'h0FC, 32'h1234_5678); rd32(10'h0FC, v, c); check("R2 header word63", v, 32'h1234_5678);
    wr32(10'h004, 32'hA5A5_0F0F); rd32(10'h004, v, c); check("R2 header word1 rewrite", v, 32'hA5A5_0F0F);
    rd32(10'h008, v, c); check("R2 word2 kept", v, 32'hDEAD_BEEF);

    wr32(10'h1C0, 32'hFFFF_FFFF); rd32(10'h1C0, v, c); check("R4 addr reg ones", v, 32'hFFFF_FFFF);
    wr32(10'h1C0, 32'h8000_1234); rd32(10'h1C0, v, c); check("R4 addr reg pattern", v, 32'h8000_1234);

    wr32(10'h1C4, 32'hFFFF_FFFF); rd32(10'h1C4, v, c); check("R5 mem base ones", v, 32'hFF00_0001);
    wr32(10'h1C4, 32'h1234_5678); rd32(10'h1C4, v, c); check("R5 mem base pattern", v, 32'h1200_0000);

    wr32(10'h1C8, 32'hFFFF_FFFF); rd32(10'h1C8, v, c); check("R6 io base ones", v, 32'hFFFC_0001);
    check("R6 io_win_off ones", io_win_off, 32'hFFFC_0000);
    wr32(10'h1C8, 32'h0007_FFFF); rd32(10'h1C8, v, c); check("R6 io base pattern", v, 32'h0004_0001);

    nb = n_req;
    xfer(1'b1, 10'h008, 4'h3, 32'h0, v, c); check("R1 partial write latency", c, 0);
    rd32(10'h008, v, c); check("R1 partial write ignored", v, 32'hDEAD_BEEF);
    xfer(1'b0, 10'h004, 4'h7, 32'h0, v, c); check("R1 partial read zero", v, 32'h0);
    xfer(1'b0, 10'h009, 4'hF, 32'h0, v, c); check("R1 misaligned read zero", v, 32'h0);
    xfer(1'b1, 10'h1C1, 4'hF, 32'hFFFF_FFFF, v, c);
    rd32(10'h1C0, v, c); check("R1 misaligned write ignored", v, 32'h8000_1234);
    xfer(1'b1, 10'h220, 4'hE, 32'h1, v, c); check("R1 partial port no stall", c, 0);
    xfer(1'b0, 10'h220, 4'h1, 32'h0, v, c); check("R1 partial port read zero", v, 32'h0);
    repeat (4) @(negedge clk);
    check("R1 partial port no cycle", n_req, nb);

    wr32(10'h100, 32'hFFFF_FFFF); rd32(10'h100, v, c); check("R10 offset 0x100", v, 32'h0);
    wr32(10'h1CC, 32'hFFFF_FFFF); rd32(10'h1CC, v, c); check("R10 offset 0x1CC", v, 32'h0);
    wr32(10'h21C, 32'hFFFF_FFFF); rd32(10'h21C, v, c); check("R10 offset 0x21C", v, 32'h0);
    wr32(10'h224, 32'hFFFF_FFFF); rd32(10'h224, v, c); check("R10 offset 0x224", v, 32'h0);
    wr32(10'h3FC, 32'hFFFF_FFFF); rd32(10'h3FC, v, c); check("R10 offset 0x3FC", v, 32'h0);
    check("R10 no downstream", n_req, nb);

    // indirect write then read, no delay
    wr32(10'h1C0, 32'h8000_0800);
    xfer(1'b1, 10'h220, 4'hF, 32'hCAFE_F00D, v, c);
    check("R8 port write latency d0 r0", c, 3);
    check("R7 write flag", {31'h0, lat_wr}, 32'h1);
    check("R7 write addr", lat_addr, 32'h8000_0800);
    check("R7 write data", lat_wdata, 32'hCAFE_F00D);
    rd32(10'h220, v, c);
    check("R7 read back", v, 32'hCAFE_F00D);
    check("R7 read flag", {31'h0, lat_wr}, 32'h0);
    check("R8 port read latency d0 r0", c, 3);

    // delays
    req_dly = 2; rsp_dly = 3;
    wr32(10'h1C0, 32'h8000_1000);
    rd32(10'h220, v, c);
    check("R7 read default data", v, dflt(32'h8000_1000));
    check("R8 port read latency d2 r3", c, 8);
    req_dly = 1; rsp_dly = 0;
    xfer(1'b1, 10'h220, 4'hF, 32'h0BAD_CAFE, v, c);
    check("R8 port write latency d1 r0", c, 4);
    check("R7 write data delayed", lat_wdata, 32'h0BAD_CAFE);
    req_dly = 0;

    // timeout
    mute = 1;
    wr32(10'h1C0, 32'h8000_2000);
    rd32(10'h220, v, c);
    check("R9 timeout read ones", v, 32'hFFFF_FFFF);
    check("R9 timeout bounded", {31'h0, (c <= TMO + 2)}, 32'h1);
    xfer(1'b1, 10'h220, 4'hF, 32'h7777_0000, v, c);
    check("R9 timeout write completes", {31'h0, (c <= TMO + 2)}, 32'h1);
    mute = 0;
    repeat (3) @(negedge clk);
    rd32(10'h220, v, c);
    check("R9 recovery read", v, 32'h7777_0000);
    rd32(10'h1C0, v, c);
    check("R12 local after port", c, 0);

    // interrupts (compared each cycle as well)
    @(negedge clk);
    irq_slot = '0;
    for (int j = 0; j < NS; j++) irq_slot[j*SW +: SW] = SW'(j);
    irq_src = 8'b0000_0101;
    #1; check("R11 slot0 and slot2", {28'h0, irq_out}, 32'h5);
    @(negedge clk);
    irq_src = 8'b1111_0000;
    #1; check("R11 slots above 3 drive nothing", {28'h0, irq_out}, 32'h0);
    @(negedge clk);
    irq_slot[7*SW +: SW] = 5'd3; irq_slot[6*SW +: SW] = 5'd3;
    irq_src = 8'b1000_0010;
    #1; check("R11 shared and slot1", {28'h0, irq_out}, 32'hA);
    @(negedge clk);
    irq_src = 8'h00;
    #1; check("R11 none", {28'h0, irq_out}, 32'h0);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule